// File: doc/BRIEF.md
# Concurrent Capture Bank with Serial Unload

This block sits next to a working datapath and observes it without ever stalling or changing it. Each strobe pulse copies the datapath word presented on its capture input into the next slot of a small register bank. A separate stream of unload requests pulls the slots out again, in the order they were filled, through one serial output pin. An off-chip checker receives that stream, along with a frame pulse marking the first bit of every word and a valid level covering every bit.

Two modulo counters keep the two activities apart. A write index advances on every strobe. A read index advances on every accepted unload request. Both wrap after the last slot. This lets capture and unload run at the same time on different slots. If the same slot is written and loaded in the same clock, the load takes the freshly written word.

Each word leaves in a fixed number of clocks, equal to its width. A request that arrives exactly as the last bit of the current word is on the pin starts the next word with no idle clock. A request that arrives earlier is dropped and recorded in a sticky error flag.

Top module: `tap_capture_serializer`

## Requirements
- R1: While reset is high and in the first cycle after it, ser_valid, ser_frame, ser_out and overrun_err are 0, and both indices point at slot 0.
- R2: A clock with cap_stb high writes cap_data into the slot named by the write index, and the write index then advances by one modulo N_REGS.
- R3: An accepted unload request loads the slot named by the read index and then advances the read index modulo N_REGS, so words leave in the order they were captured, including across the wrap.
- R4: A loaded word appears on ser_out in the cycle after the accepting edge, MSB first, one bit per clock, for exactly WORD_W clocks, with ser_valid high for all of them.
- R5: ser_frame is high for one clock, together with the first bit of each word, and never without ser_valid.
- R6: A request sampled while the last bit of a word is on ser_out is accepted, and the next word's first bit follows with no idle clock.
- R7: If cap_stb and an accepted request address the same slot in the same clock, the unloaded word is the cap_data of that clock.
- R8: A request sampled while more than one bit of the current word remains is ignored: the read index does not advance and the word in flight is unchanged. It sets overrun_err.
- R9: overrun_err, once set, stays 1 until reset.
- R10: A capture into the slot whose word is currently shifting does not alter the bits still to come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_data | input | WORD_W | Datapath word to capture |
| cap_stb | input | 1 | Capture strobe, one word per high clock |
| unload_req | input | 1 | Request to start unloading the next slot |
| ser_out | output | 1 | Serial data, MSB first |
| ser_frame | output | 1 | High with the first bit of each word |
| ser_valid | output | 1 | High while a word bit is on ser_out |
| overrun_err | output | 1 | Sticky flag: a request arrived while busy |

## Verification
The bench builds the block with four slots of eight-bit words. With four slots, the write and read indices wrap every few words, so a long random run repeatedly crosses the wrap point while capture and unload interleave at different distances. With eight-bit words, a request can land in any of seven busy clocks to provoke an overrun, or in the last-bit clock to test seamless chaining. Directed sequences cover the same-slot collision from an empty bank, a capture into the slot still being shifted, and the sticky error across a later reset.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  // Width of an index that counts 0 .. m-1 (at least one bit).
  function automatic int idx_width(input int m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/tcs_modcnt.sv
module tcs_modcnt #(
  parameter int MOD = 4,
  parameter int AW  = tcs_pkg::idx_width(MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(MOD - 1);

  always_ff @(posedge clk) begin
    if (rst)
      idx <= '0;
    else if (adv)
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/tcs_bank.sv
module tcs_bank #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int AW = tcs_pkg::idx_width(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tcs_unloader.sv
module tcs_unloader #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         ser_out,
  output logic         ser_frame,
  output logic         ser_valid
);
  localparam int CW = tcs_pkg::idx_width(W);
  localparam logic [CW-1:0] FIRST_LEFT = CW'(W - 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      left      <= '0;
      ser_frame <= 1'b0;
      ser_valid <= 1'b0;
    end else begin
      ser_frame <= load;
      ser_valid <= load | (left != '0);
      if (load) begin
        sreg <= word;
        left <= FIRST_LEFT;
      end else begin
        sreg <= {sreg[W-2:0], 1'b0};
        if (left != '0)
          left <= left - 1'b1;
      end
    end
  end

  assign ser_out = sreg[W-1];
  assign busy    = (left != '0);
endmodule

// File: rtl/tap_capture_serializer.sv
module tap_capture_serializer #(
  parameter int N_REGS = 4,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cap_data,
  input  logic              cap_stb,
  input  logic              unload_req,
  output logic              ser_out,
  output logic              ser_frame,
  output logic              ser_valid,
  output logic              overrun_err
);
  localparam int AW = tcs_pkg::idx_width(N_REGS);

  logic [AW-1:0]     wr_idx;
  logic [AW-1:0]     rd_idx;
  logic [WORD_W-1:0] bank_q;
  logic [WORD_W-1:0] load_word;
  logic              unl_busy;
  logic              accept;

  assign accept = unload_req & ~unl_busy;

  tcs_modcnt #(.MOD(N_REGS), .AW(AW)) u_wcnt (
    .clk(clk), .rst(rst), .adv(cap_stb), .idx(wr_idx)
  );

  tcs_modcnt #(.MOD(N_REGS), .AW(AW)) u_rcnt (
    .clk(clk), .rst(rst), .adv(accept), .idx(rd_idx)
  );

  tcs_bank #(.N(N_REGS), .W(WORD_W), .AW(AW)) u_bank (
    .clk(clk), .we(cap_stb), .waddr(wr_idx), .wdata(cap_data),
    .raddr(rd_idx), .rdata(bank_q)
  );

  // Same-slot write and load: forward the word being written.
  assign load_word = (cap_stb && (wr_idx == rd_idx)) ? cap_data : bank_q;

  tcs_unloader #(.W(WORD_W)) u_unl (
    .clk(clk), .rst(rst), .load(accept), .word(load_word),
    .busy(unl_busy), .ser_out(ser_out), .ser_frame(ser_frame),
    .ser_valid(ser_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)
      overrun_err <= 1'b0;
    else if (unload_req && unl_busy)
      overrun_err <= 1'b1;
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst,
  input logic unload_req,
  input logic ser_frame,
  input logic ser_valid,
  input logic overrun_err
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= 0;
    else if (ser_valid)
      run_q <= ser_frame ? 1 : run_q + 1;
    else
      run_q <= 0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!ser_valid && !ser_frame && !overrun_err))
    else $error("R1 outputs not idle after reset");

  p_frame_in_valid_r5: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> ser_valid)
    else $error("R5 frame without valid");

  p_start_framed_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_valid) |-> ser_frame)
    else $error("R5 word started without frame");

  p_word_not_long_r4: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !ser_frame) |-> (run_q < W))
    else $error("R4 word longer than width");

  p_word_not_short_r4: assert property (@(posedge clk) disable iff (rst)
    (!ser_valid && $past(ser_valid)) |-> (run_q == W))
    else $error("R4 word ended early");

  p_chain_full_r6: assert property (@(posedge clk) disable iff (rst)
    (ser_frame && $past(ser_valid)) |-> (run_q == W))
    else $error("R6 new frame cut previous word");

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overrun_err |=> overrun_err)
    else $error("R9 overrun flag dropped");

  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_err) |-> $past(unload_req && ser_valid))
    else $error("R8 overrun without busy request");
endmodule

bind tap_capture_serializer tcs_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .unload_req(unload_req), .ser_frame(ser_frame),
  .ser_valid(ser_valid), .overrun_err(overrun_err)
);

// File: tb/tap_capture_serializer_tb.sv
`timescale 1ns/1ps
module tap_capture_serializer_tb;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cap_data = '0;
  logic         cap_stb = 1'b0;
  logic         unload_req = 1'b0;
  logic         ser_out, ser_frame, ser_valid, overrun_err;

  always #4 clk = ~clk;

  tap_capture_serializer #(.N_REGS(N), .WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .cap_data(cap_data), .cap_stb(cap_stb),
    .unload_req(unload_req), .ser_out(ser_out), .ser_frame(ser_frame),
    .ser_valid(ser_valid), .overrun_err(overrun_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the requirements
  logic [W-1:0] mb [N];
  int wp, rp, bcnt, cap_n, unl_n;
  bit exp_ovr;
  logic [W-1:0] expq [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick_word(input bit stb, input logic [W-1:0] d);
    return (stb && wp == rp) ? d : mb[rp];  // R7 forwarding rule
  endfunction

  // Called aligned to a negedge: set inputs for the next posedge, update model.
  task automatic drive(input bit stb, input logic [W-1:0] d, input bit req);
    bit acc;
    cap_stb = stb; cap_data = d; unload_req = req;
    acc = req && (bcnt == 0);
    if (req && !acc) exp_ovr = 1;
    if (acc) begin
      expq.push_back(pick_word(stb, d));
      rp = (rp + 1) % N; bcnt = W - 1; unl_n++;
    end else if (bcnt > 0) bcnt--;
    if (stb) begin mb[wp] = d; wp = (wp + 1) % N; cap_n++; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0);
  endtask

  task automatic do_reset();
    rst = 1; cap_stb = 0; unload_req = 0; cap_data = '0;
    repeat (3) @(negedge clk);
    chk(!ser_valid && !ser_frame && !ser_out && !overrun_err, "R1 outputs during reset",
        {ser_valid, ser_frame, ser_out, overrun_err}, 0);
    rst = 0;
    wp = 0; rp = 0; bcnt = 0; cap_n = 0; unl_n = 0; exp_ovr = 0;
    expq.delete();
    @(negedge clk);
    chk(!ser_valid && !ser_frame && !overrun_err, "R1 outputs after reset",
        {ser_valid, ser_frame, overrun_err}, 0);
  endtask

  // Serial receiver
  int bits = 0;
  logic [W-1:0] rx;
  always @(negedge clk) begin
    if (rst) bits = 0;
    else begin
      if (ser_frame && !ser_valid) chk(0, "R5 frame without valid", 1, 0);
      if (ser_valid) begin
        if (ser_frame) begin
          if (bits != 0) chk(0, "R6 frame inside a word", bits, 0);
          bits = 1; rx = {{(W-1){1'b0}}, ser_out};
        end else if (bits == 0) begin
          chk(0, "R5 valid bit without frame", 1, 0);
        end else begin
          rx = {rx[W-2:0], ser_out}; bits++;
        end
        if (bits == W) begin
          if (expq.size() == 0) chk(0, "R3 unexpected word", rx, 0);
          else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            chk(rx === e, "R3 R4 word order and MSB-first bits", rx, e);
          end
          bits = 0;
        end
      end else if (bits != 0) begin
        chk(0, "R4 word shorter than width", bits, W);
        bits = 0;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R7: empty bank, write and load slot 0 in the same clock
    drive(1, 8'hA5, 1);
    idle(W + 2);
    chk(expq.size() == 0, "R7 forwarded word delivered", expq.size(), 0);

    // R2: fill four slots, crossing the wrap of the write index
    drive(1, 8'h11, 0); drive(1, 8'h22, 0); drive(1, 8'h33, 0); drive(1, 8'h44, 0);
    // R6: back-to-back unloads; R10: overwrite the slot being shifted
    drive(0, '0, 1);
    drive(1, 8'h55, 0);  // write index now at slot 1, word 11 is in flight
    for (int i = 0; i < 40; i++) drive(0, '0, (bcnt == 0) && (unl_n < cap_n));
    idle(W + 2);
    chk(expq.size() == 0, "R2 R6 R10 directed words delivered", expq.size(), 0);
    chk(overrun_err == 0, "R8 no overrun on in-time requests", overrun_err, 0);

    // R8: request while busy is ignored and flagged
    drive(1, 8'hC3, 0);
    drive(0, '0, 1);
    drive(0, '0, 0);
    drive(0, '0, 1);     // busy: ignored
    idle(2);
    chk(overrun_err == 1, "R8 overrun flagged", overrun_err, 1);
    idle(W + 2);
    chk(expq.size() == 0, "R8 stream unchanged by ignored request", expq.size(), 0);
    drive(1, 8'h3C, 0);
    drive(0, '0, 1);     // must read the next slot, not repeat
    idle(W + 2);
    chk(expq.size() == 0, "R8 read index not advanced by ignored request", expq.size(), 0);
    chk(overrun_err == 1, "R9 overrun stays set", overrun_err, 1);

    // Constrained random interleaving obeying the no-gap, no-overwrite rules
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 4000; i++) begin
      bit s, r;
      s = (($urandom % 3) == 0) && ((cap_n - unl_n) < N);
      r = (bcnt == 0) && (((cap_n - unl_n) >= 1) || s) && (($urandom % 2) == 0);
      drive(s, W'($urandom), r);
    end
    idle(W + 2);
    chk(expq.size() == 0, "R3 random run drained", expq.size(), 0);
    chk(cap_n - unl_n <= N, "R2 no slot overwritten early", cap_n - unl_n, N);
    chk(overrun_err == exp_ovr, "R9 flag after random run", overrun_err, exp_ovr);

    // R9: only reset clears the flag
    do_reset();
    chk(overrun_err == 0, "R9 cleared by reset", overrun_err, 0);
    drive(1, 8'h5A, 0);
    drive(0, '0, 1);
    idle(W + 2);
    chk(expq.size() == 0, "R1 first slot after reset", expq.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule